// File: doc/BRIEF.md
# Windowed Integer Register File with Speculative Working Copy

This block holds the integer registers of a processor that uses overlapping register windows. The pipeline reads operands from, and writes results into, a small 32-entry working copy. Results land there speculatively, as soon as they are produced. A separate, larger architectural store holds the retired state of every window. It is written through a commit port at the end of the pipeline, once a result is known to be free of exceptions. Each commit carries the window it belongs to, so retirement may lag behind the current window.

The visible register space has four groups of eight. Registers 0 to 7 are globals, shared by all windows. Registers 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. The outs of window w are the same storage as the ins of window (w+1) mod NWIN.

A save moves the current window pointer up by one and a restore moves it down by one. During the following cycle the block raises a stall. At the end of that cycle the working copy is rebuilt. The group that is shared between the old and new windows is moved inside the working copy, and the other 16 window registers are loaded from the architectural store. A flush reloads all 31 nonzero working registers from the architectural state of the current window and discards every speculative result.

Top module: `winreg_file`

## Requirements
- R1: After reset, every register reads zero on both read ports, `cwp_o` is 0 and `stall_o` is 0.
- R2: A speculative write (`wr_en_i`, nonzero `wr_addr_i`) accepted at a clock edge is returned from the next cycle on either read port; the two read ports are combinational and independent.
- R3: Register 0 always reads zero; speculative and commit writes addressed to register 0 change nothing.
- R4: A commit write updates only the architectural store; working registers read unchanged until a flush or window refill loads them.
- R5: `flush_i` loads registers 1 to 31 from the architectural view of the current window, including a commit made in the same cycle; it takes priority over a same-cycle speculative write and window request (the request is dropped and `cwp_o` is unchanged), and `stall_o` is low in the next cycle.
- R6: A window request with `win_save_i`=1, when not stalled, sets `cwp_o` to (cwp+1) mod NWIN at the edge and raises `stall_o` for exactly the next cycle; at the end of that cycle, registers 24 to 31 take the old contents of registers 8 to 15, registers 8 to 23 are loaded from the architectural store of the new window, and globals are untouched.
- R7: A window request with `win_save_i`=0 sets `cwp_o` to (cwp-1) mod NWIN and stalls for one cycle in the same way; registers 8 to 15 then take the old contents of 24 to 31, and registers 16 to 31 are loaded from the architectural store of the new window.
- R8: While `stall_o` is high, speculative writes and window requests are ignored, while a commit write is accepted and is already seen by the refill at the end of that cycle.
- R9: Commit address mapping: registers 1 to 7 are shared by all windows; for window w, registers 16 to 23 are its locals, 24 to 31 are its ins, and 8 to 15 are the ins of window (w+1) mod NWIN.
- R10: Over a long mixed sequence of writes, commits, saves, restores and flushes, every read matches a flat model of the requirements above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd0_addr_i | input | 5 | Read port 0 register number |
| rd0_data_o | output | XLEN | Read port 0 data |
| rd1_addr_i | input | 5 | Read port 1 register number |
| rd1_data_o | output | XLEN | Read port 1 data |
| wr_en_i | input | 1 | Speculative write enable |
| wr_addr_i | input | 5 | Speculative write register number |
| wr_data_i | input | XLEN | Speculative write data |
| cm_en_i | input | 1 | Commit write enable |
| cm_win_i | input | log2(NWIN) | Window the committed result belongs to |
| cm_addr_i | input | 5 | Commit register number |
| cm_data_i | input | XLEN | Commit data |
| win_req_i | input | 1 | Window change request |
| win_save_i | input | 1 | 1 = save (pointer up), 0 = restore (pointer down) |
| flush_i | input | 1 | Exception flush: reload working copy from architectural state |
| stall_o | output | 1 | High during the refill cycle; read data must not be used |
| cwp_o | output | log2(NWIN) | Current window pointer |

## Verification
The directed patterns serve different purposes. Speculative values are written first and commits with different values come after them, so a read tells the speculative level from the architectural one. Commits to every window with distinct values let each refill show whether the shared group was moved inside the working copy or reloaded from the store. Eight saves in a row and eight restores in a row cover the pointer wrap in both directions. Each save is followed by a flush, which checks the mapping of outs onto the ins of the next window. Stimulus injected in the stall cycle and beside a flush shows which input wins. A long pseudo-random mix of all operations is then compared every cycle, across all 32 registers, against a flat model.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    // registers per visible group (globals, outs, locals, ins)
    localparam int GRP    = 8;
    localparam int NREG   = 4 * GRP;
    localparam int REG_AW = $clog2(NREG);
    // first register number of each group
    localparam int OUT_LO = GRP;
    localparam int LOC_LO = 2 * GRP;
    localparam int IN_LO  = 3 * GRP;
endpackage

// File: rtl/winreg_arch_store.sv
module winreg_arch_store
    import winreg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NWIN = 8,
    localparam int WIN_W = $clog2(NWIN),
    localparam int NARCH = GRP + 2 * GRP * NWIN,
    localparam int AW    = $clog2(NARCH)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        cm_en_i,
    input  logic [WIN_W-1:0]            cm_win_i,
    input  logic [REG_AW-1:0]           cm_addr_i,
    input  logic [XLEN-1:0]             cm_data_i,
    input  logic [WIN_W-1:0]            view_win_i,
    output logic [NREG-1:0][XLEN-1:0]   view_o
);
    typedef struct packed {
        logic [NARCH-1:0][XLEN-1:0] r;
    } arch_t;

    arch_t st_d, st_q;

    // storage layout: globals, then per window its ins followed by its locals
    function automatic logic [AW-1:0] aidx(input logic [WIN_W-1:0] w,
                                           input logic [REG_AW-1:0] r);
        int wi, ri, pos;
        wi = int'(w);
        ri = int'(r);
        if (ri < OUT_LO)
            pos = ri;
        else if (ri < LOC_LO)
            pos = GRP + ((wi + 1) % NWIN) * 2 * GRP + (ri - OUT_LO);
        else if (ri < IN_LO)
            pos = GRP + wi * 2 * GRP + GRP + (ri - LOC_LO);
        else
            pos = GRP + wi * 2 * GRP + (ri - IN_LO);
        return AW'(pos);
    endfunction

    always_comb begin
        st_d = st_q;
        if (cm_en_i && (cm_addr_i != '0))
            st_d.r[aidx(cm_win_i, cm_addr_i)] = cm_data_i;
        // view reflects this cycle's commit so a refill sees it
        view_o = '0;
        for (int i = 1; i < NREG; i++)
            view_o[i] = st_d.r[aidx(view_win_i, REG_AW'(i))];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/winreg_win_ctrl.sv
module winreg_win_ctrl #(
    parameter int NWIN = 8,
    localparam int WIN_W = $clog2(NWIN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             win_req_i,
    input  logic             win_save_i,
    input  logic             flush_i,
    output logic [WIN_W-1:0] cwp_o,
    output logic             busy_o,
    output logic             refill_save_o,
    output logic             refill_rest_o
);
    typedef struct packed {
        logic [WIN_W-1:0] cwp;
        logic             busy;
        logic             save;
    } ctrl_t;

    localparam logic [WIN_W-1:0] TOP_WIN = WIN_W'(NWIN - 1);

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.busy = 1'b0;
        end else if (win_req_i) begin
            st_d.busy = 1'b1;
            st_d.save = win_save_i;
            if (win_save_i)
                st_d.cwp = (st_q.cwp == TOP_WIN) ? '0 : st_q.cwp + 1'b1;
            else
                st_d.cwp = (st_q.cwp == '0) ? TOP_WIN : st_q.cwp - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cwp_o         = st_q.cwp;
    assign busy_o        = st_q.busy;
    assign refill_save_o = st_q.busy &  st_q.save & ~flush_i;
    assign refill_rest_o = st_q.busy & ~st_q.save & ~flush_i;
endmodule

// File: rtl/winreg_work_store.sv
module winreg_work_store
    import winreg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_en_i,
    input  logic [REG_AW-1:0]          wr_addr_i,
    input  logic [XLEN-1:0]            wr_data_i,
    input  logic                       load_all_i,
    input  logic                       refill_save_i,
    input  logic                       refill_rest_i,
    input  logic [NREG-1:0][XLEN-1:0]  view_i,
    input  logic [REG_AW-1:0]          rd0_addr_i,
    input  logic [REG_AW-1:0]          rd1_addr_i,
    output logic [XLEN-1:0]            rd0_data_o,
    output logic [XLEN-1:0]            rd1_data_o
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] r;
    } work_t;

    work_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_all_i) begin
            for (int i = 0; i < NREG; i++)
                st_d.r[i] = view_i[i];
        end else if (refill_save_i) begin
            for (int j = 0; j < GRP; j++) begin
                st_d.r[IN_LO + j]  = st_q.r[OUT_LO + j];
                st_d.r[OUT_LO + j] = view_i[OUT_LO + j];
                st_d.r[LOC_LO + j] = view_i[LOC_LO + j];
            end
        end else if (refill_rest_i) begin
            for (int j = 0; j < GRP; j++) begin
                st_d.r[OUT_LO + j] = st_q.r[IN_LO + j];
                st_d.r[LOC_LO + j] = view_i[LOC_LO + j];
                st_d.r[IN_LO + j]  = view_i[IN_LO + j];
            end
        end else if (wr_en_i) begin
            st_d.r[wr_addr_i] = wr_data_i;
        end
        st_d.r[0] = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd0_data_o = st_q.r[rd0_addr_i];
    assign rd1_data_o = st_q.r[rd1_addr_i];
endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NWIN = 8,
    localparam int WIN_W = $clog2(NWIN)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_AW-1:0] rd0_addr_i,
    output logic [XLEN-1:0]   rd0_data_o,
    input  logic [REG_AW-1:0] rd1_addr_i,
    output logic [XLEN-1:0]   rd1_data_o,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic              cm_en_i,
    input  logic [WIN_W-1:0]  cm_win_i,
    input  logic [REG_AW-1:0] cm_addr_i,
    input  logic [XLEN-1:0]   cm_data_i,
    input  logic              win_req_i,
    input  logic              win_save_i,
    input  logic              flush_i,
    output logic              stall_o,
    output logic [WIN_W-1:0]  cwp_o
);
    logic [NREG-1:0][XLEN-1:0] view;
    logic                      refill_save, refill_rest;

    winreg_win_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .win_req_i     (win_req_i),
        .win_save_i    (win_save_i),
        .flush_i       (flush_i),
        .cwp_o         (cwp_o),
        .busy_o        (stall_o),
        .refill_save_o (refill_save),
        .refill_rest_o (refill_rest)
    );

    winreg_arch_store #(.XLEN(XLEN), .NWIN(NWIN)) u_arch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cm_en_i    (cm_en_i),
        .cm_win_i   (cm_win_i),
        .cm_addr_i  (cm_addr_i),
        .cm_data_i  (cm_data_i),
        .view_win_i (cwp_o),
        .view_o     (view)
    );

    winreg_work_store #(.XLEN(XLEN)) u_work (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .load_all_i    (flush_i),
        .refill_save_i (refill_save),
        .refill_rest_i (refill_rest),
        .view_i        (view),
        .rd0_addr_i    (rd0_addr_i),
        .rd1_addr_i    (rd1_addr_i),
        .rd0_data_o    (rd0_data_o),
        .rd1_data_o    (rd1_data_o)
    );
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk
    import winreg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NWIN = 8,
    localparam int WIN_W = $clog2(NWIN)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [REG_AW-1:0] rd0_addr_i,
    input logic [XLEN-1:0]   rd0_data_o,
    input logic [REG_AW-1:0] rd1_addr_i,
    input logic [XLEN-1:0]   rd1_data_o,
    input logic              wr_en_i,
    input logic [REG_AW-1:0] wr_addr_i,
    input logic [XLEN-1:0]   wr_data_i,
    input logic              win_req_i,
    input logic              win_save_i,
    input logic              flush_i,
    input logic              stall_o,
    input logic [WIN_W-1:0]  cwp_o
);
    localparam logic [WIN_W-1:0] TOP_WIN = WIN_W'(NWIN - 1);

    assert_r0_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd1_addr_i == '0) |-> (rd1_data_o == '0));

    assert_write_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !stall_o && !flush_i && (wr_addr_i != '0))
        |=> ((rd0_addr_i != $past(wr_addr_i)) || (rd0_data_o == $past(wr_data_i))));

    assert_flush_unstalls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !stall_o);

    assert_flush_keeps_cwp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> $stable(cwp_o));

    assert_save_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_req_i && win_save_i && !stall_o && !flush_i)
        |=> (stall_o && (cwp_o == (($past(cwp_o) == TOP_WIN) ? '0 : $past(cwp_o) + 1'b1))));

    assert_stall_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> !stall_o);

    assert_restore_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_req_i && !win_save_i && !stall_o && !flush_i)
        |=> (stall_o && (cwp_o == (($past(cwp_o) == '0) ? TOP_WIN : $past(cwp_o) - 1'b1))));

    assert_stall_holds_cwp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> $stable(cwp_o));
endmodule

bind winreg_file winreg_file_chk #(.XLEN(XLEN), .NWIN(NWIN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd0_addr_i (rd0_addr_i),
    .rd0_data_o (rd0_data_o),
    .rd1_addr_i (rd1_addr_i),
    .rd1_data_o (rd1_data_o),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .win_req_i  (win_req_i),
    .win_save_i (win_save_i),
    .flush_i    (flush_i),
    .stall_o    (stall_o),
    .cwp_o      (cwp_o)
);

// File: tb/sim_winreg_file.sv
`timescale 1ns/100ps
module sim_winreg_file;
    localparam int XLEN  = 64;
    localparam int NWIN  = 8;
    localparam int WIN_W = $clog2(NWIN);
    localparam int NARCH = 8 + 16 * NWIN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       rd0_addr = '0, rd1_addr = '0;
    logic [XLEN-1:0]  rd0_data, rd1_data;
    logic             wr_en = 1'b0;
    logic [4:0]       wr_addr = '0;
    logic [XLEN-1:0]  wr_data = '0;
    logic             cm_en = 1'b0;
    logic [WIN_W-1:0] cm_win = '0;
    logic [4:0]       cm_addr = '0;
    logic [XLEN-1:0]  cm_data = '0;
    logic             win_req = 1'b0, win_save = 1'b0, flush = 1'b0;
    logic             stall;
    logic [WIN_W-1:0] cwp;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // flat model
    logic [XLEN-1:0] arch_m [NARCH];
    logic [XLEN-1:0] wk_m [32];
    int cwp_m = 0;
    bit busy_m = 0;
    bit save_m = 0;

    always #10 clk = ~clk;

    winreg_file #(.XLEN(XLEN), .NWIN(NWIN)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .rd0_addr_i(rd0_addr), .rd0_data_o(rd0_data),
        .rd1_addr_i(rd1_addr), .rd1_data_o(rd1_data),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .cm_en_i(cm_en), .cm_win_i(cm_win), .cm_addr_i(cm_addr), .cm_data_i(cm_data),
        .win_req_i(win_req), .win_save_i(win_save), .flush_i(flush),
        .stall_o(stall), .cwp_o(cwp)
    );

    // R9 mapping: globals, then per window ins then locals
    function automatic int midx(input int w, input int r);
        if (r < 8)  return r;
        if (r < 16) return 8 + ((w + 1) % NWIN) * 16 + (r - 8);
        if (r < 24) return 8 + w * 16 + 8 + (r - 16);
        return 8 + w * 16 + (r - 24);
    endfunction

    function automatic logic [XLEN-1:0] mkval(input int a, input int b);
        return {16'hC0DE ^ 16'(a), 16'(b), 16'(a * 7 + b), 16'(b * 13 + 5)};
    endfunction

    task automatic chk(input string tag, input string what, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(tag, "stall", {63'b0, stall}, {63'b0, busy_m});
        chk(tag, "cwp", XLEN'(cwp), XLEN'(cwp_m));
        for (int r = 0; r < 16; r++) begin
            rd0_addr = 5'(r);
            rd1_addr = 5'(r + 16);
            #0.5;
            chk(tag, $sformatf("reg%0d", r), rd0_data, wk_m[r]);
            chk(tag, $sformatf("reg%0d", r + 16), rd1_data, wk_m[r + 16]);
        end
    endtask

    task automatic model_edge();
        logic [XLEN-1:0] wk_old [32];
        if (cm_en && cm_addr != 0)
            arch_m[midx(int'(cm_win), int'(cm_addr))] = cm_data;
        wk_old = wk_m;
        if (flush) begin
            for (int r = 1; r < 32; r++) wk_m[r] = arch_m[midx(cwp_m, r)];
            busy_m = 0;
        end else if (busy_m) begin
            for (int j = 0; j < 8; j++) begin
                if (save_m) begin
                    wk_m[24 + j] = wk_old[8 + j];
                    wk_m[8 + j]  = arch_m[midx(cwp_m, 8 + j)];
                    wk_m[16 + j] = arch_m[midx(cwp_m, 16 + j)];
                end else begin
                    wk_m[8 + j]  = wk_old[24 + j];
                    wk_m[16 + j] = arch_m[midx(cwp_m, 16 + j)];
                    wk_m[24 + j] = arch_m[midx(cwp_m, 24 + j)];
                end
            end
            busy_m = 0;
        end else begin
            if (wr_en && wr_addr != 0) wk_m[wr_addr] = wr_data;
            if (win_req) begin
                busy_m = 1;
                save_m = win_save;
                cwp_m = win_save ? (cwp_m + 1) % NWIN : (cwp_m + NWIN - 1) % NWIN;
            end
        end
    endtask

    task automatic step(input bit we, input int wa, input logic [XLEN-1:0] wd,
                        input bit ce, input int cw, input int ca, input logic [XLEN-1:0] cd,
                        input bit rq, input bit sv, input bit fl, input string tag);
        wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        cm_en = ce; cm_win = WIN_W'(cw); cm_addr = 5'(ca); cm_data = cd;
        win_req = rq; win_save = sv; flush = fl;
        @(posedge clk);
        model_edge();
        #1;
        wr_en = 0; cm_en = 0; win_req = 0; flush = 0;
        check_state(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, '0, 0, 0, 0, '0, 0, 0, 0, tag);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < NARCH; i++) arch_m[i] = '0;
        for (int i = 0; i < 32; i++) wk_m[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_state("R1");

        // R2: speculative writes to every register
        for (int r = 1; r < 32; r++)
            step(1, r, mkval(1, r), 0, 0, 0, '0, 0, 0, 0, "R2");

        // R3: register 0 writes at both levels
        step(1, 0, mkval(9, 9), 1, 0, 0, mkval(9, 8), 0, 0, 0, "R3");

        // R4: commits leave working copy unchanged
        for (int r = 1; r < 32; r++)
            step(0, 0, '0, 1, 0, r, mkval(2, r), 0, 0, 0, "R4");

        // R5: flush with same-cycle commit, write and window request
        step(1, 5, mkval(3, 5), 1, 0, 7, mkval(3, 7), 1, 1, 1, "R5");
        idle("R5");

        // R9: distinct commits in every window
        for (int w = 0; w < NWIN; w++)
            for (int r = 1; r < 32; r++)
                step(0, 0, '0, 1, w, r, mkval(16 + w, r), 0, 0, 0, "R9");

        // R6: eight saves, wrapping the pointer
        for (int k = 0; k < NWIN; k++) begin
            step(0, 0, '0, 0, 0, 0, '0, 1, 1, 0, "R6");
            idle("R6");
        end

        // R8: stimulus inside the stall cycle
        step(1, 10, mkval(4, 10), 0, 0, 0, '0, 1, 1, 0, "R8");
        step(1, 20, mkval(4, 20), 1, cwp_m, 17, mkval(4, 17), 1, 0, 0, "R8");
        idle("R8");

        // R7: eight restores, wrapping the pointer
        for (int k = 0; k < NWIN; k++) begin
            step(0, 0, '0, 0, 0, 0, '0, 1, 0, 0, "R7");
            idle("R7");
        end

        // R9: flush in every window shows the outs-to-ins overlap
        for (int k = 0; k < NWIN; k++) begin
            step(0, 0, '0, 0, 0, 0, '0, 1, 1, 0, "R9");
            idle("R9");
            step(0, 0, '0, 0, 0, 0, '0, 0, 0, 1, "R9");
        end

        // R10: pseudo-random mix
        lf = 32'h1234_5678;
        for (int n = 0; n < 1500; n++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            step(lf[0], int'(lf[8:4]), {lf, ~lf}, lf[1], int'(lf[11:9]), int'(lf[16:12]),
                 {~lf, lf}, (lf[19:17] == 3'd0), lf[20], (lf[24:21] == 4'd0), "R10");
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule